// File: doc/BRIEF.md
# Edge-Captured Interrupt Request Synchronizer

This block turns activity on four external interrupt pins into four interrupt-request flags in the internal clock domain. Each pin feeds a capture flip-flop that is clocked by the pin itself, so an active edge is recorded at once, even if the pin returns to its idle level before the next clock edge. Two flip-flops on the internal clock then carry the captured event into the clock domain. The last stage gives a one-cycle pulse that sets the matching request flag. Once the first synchronizer stage has taken the event, the capture flip-flop is cleared again so that it can record the next edge.

Each line also takes an internal peripheral strobe, which is ORed into the flag set path without passing through the synchronizer. The line that can be shared with the serial port has its own input: a single serial-mode bit decides whether that flag follows its external pin or the serial receiver strobe. The flags stay set until software clears them with per-bit clear strobes. Priority, masking and vectoring are handled elsewhere.

Top module: `irq_capture_sync`

## Requirements
- R1: An active edge on a pin is captured without waiting for the clock. A pulse narrower than one clock period on a falling-edge line still sets its flag.
- R2: A flag goes high on the third rising clock edge after the active pin edge. It is still low after the second rising clock edge.
- R3: Lines whose bit is set in FALL_MASK respond to falling pin edges. The other lines respond to rising edges. With the default FALL_MASK = 4'b1001, lines 0 and 3 are falling-edge lines and lines 1 and 2 are rising-edge lines. An edge in the other direction sets no flag.
- R4: When int_stb_i[i] is high at a rising clock edge, flag_o[i] is high after that edge. This holds in either serial mode.
- R5: While ser_mode_i is 1, edges on the pin of line SER_LINE (default 3) are ignored. While ser_mode_i is 1, ser_rx_stb_i high at a clock edge sets flag_o[SER_LINE] at that edge.
- R6: While ser_mode_i is 0, ser_rx_stb_i has no effect on any flag.
- R7: A set flag stays set until its own bit of flag_clr_i is high at a clock edge. A clear strobe affects only the flags whose clear bits are set.
- R8: If a set request and a clear strobe for the same flag occur in the same cycle, the flag ends up set.
- R9: Once a request has been transferred, the capture stage is re-armed, so a later active edge on the same pin raises the flag again.
- R10: While rst_n is low, all flags read 0 even with internal strobes active. Pin edges that occur during reset leave no request behind.
- R11: One pin edge sets a flag only once. If that flag is cleared in the cycle right after it rises, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | LINES | External interrupt pins |
| int_stb_i | input | LINES | One-cycle internal peripheral request strobes |
| ser_rx_stb_i | input | 1 | One-cycle serial receiver request for line SER_LINE |
| ser_mode_i | input | 1 | 1 = line SER_LINE is driven by the serial receiver; 0 = it is driven by its pin |
| flag_clr_i | input | LINES | Per-bit flag clear strobes |
| flag_o | output | LINES | Interrupt request flags |

## Verification
A capture flip-flop that stays set shows up as a flag that rises again within three cycles of a clear. A capture flip-flop that is never set shows up as a flag that stays low three cycles after an active edge. If the synchronizer pulse is longer than one cycle, a flag cleared right after it rises comes back on the next edge. A wrong source select on the shared line appears within one clock of a receiver strobe, or three clocks after a pin edge, as a flag set when it should stay low or low when it should be set.

// File: rtl/irq_sync_pkg.sv
package irq_sync_pkg;

    // Which pin transition a capture stage reacts to
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    // Map one bit of a per-line polarity mask onto the edge selector
    function automatic edge_sel_e edge_from_bit(input logic fall_bit);
        return fall_bit ? EDGE_FALL : EDGE_RISE;
    endfunction

endpackage

// File: rtl/irq_edge_capture.sv
// Capture stage clocked by the pin itself; cleared asynchronously once
// the clock domain has taken the event.
module irq_edge_capture
    import irq_sync_pkg::*;
#(
    parameter edge_sel_e EDGE = EDGE_FALL
) (
    input  logic pin_i,
    input  logic clr_i,
    output logic cap_o
);

    logic cap_q;

    generate
        if (EDGE == EDGE_FALL) begin : g_fall
            always_ff @(negedge pin_i or posedge clr_i) begin
                if (clr_i) cap_q <= 1'b0;
                else       cap_q <= 1'b1;
            end
        end else begin : g_rise
            always_ff @(posedge pin_i or posedge clr_i) begin
                if (clr_i) cap_q <= 1'b0;
                else       cap_q <= 1'b1;
            end
        end
    endgenerate

    assign cap_o = cap_q;

endmodule

// File: rtl/irq_sync_2ff.sv
// Two-stage synchronizer across all lines; stage two is the request pulse.
module irq_sync_2ff #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] stage1_o,
    output logic [W-1:0] stage2_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage1_o = st_q.s1;
    assign stage2_o = st_q.s2;

endmodule

// File: rtl/irq_flag_reg.sv
// Request flags: set by synchronized pin pulses or internal strobes,
// cleared per bit; a set beats a clear in the same cycle.
module irq_flag_reg #(
    parameter int W        = 4,
    parameter int SER_LINE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_pulse_i,
    input  logic [W-1:0] int_stb_i,
    input  logic         rx_stb_i,
    input  logic         ser_mode_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } flag_state_t;

    flag_state_t fl_d, fl_q;
    logic [W-1:0] set_req;

    always_comb begin
        set_req = ext_pulse_i | int_stb_i;
        if (ser_mode_i) begin
            // shared line follows the serial receiver, pin path is dropped
            set_req[SER_LINE] = int_stb_i[SER_LINE] | rx_stb_i;
        end
        fl_d       = fl_q;
        fl_d.flags = (fl_q.flags & ~clr_i) | set_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag_o = fl_q.flags;

endmodule

// File: rtl/irq_capture_sync.sv
module irq_capture_sync
    import irq_sync_pkg::*;
#(
    parameter int               LINES     = 4,
    parameter int               SER_LINE  = 3,
    parameter logic [LINES-1:0] FALL_MASK = 4'b1001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    input  logic [LINES-1:0] int_stb_i,
    input  logic             ser_rx_stb_i,
    input  logic             ser_mode_i,
    input  logic [LINES-1:0] flag_clr_i,
    output logic [LINES-1:0] flag_o
);

    logic [LINES-1:0] cap;
    logic [LINES-1:0] cap_clr;
    logic [LINES-1:0] sync_s1;
    logic [LINES-1:0] sync_pulse;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            localparam edge_sel_e EDGE_G = edge_from_bit(FALL_MASK[g]);
            // re-arm as soon as the first synchronizer stage holds the event
            assign cap_clr[g] = sync_s1[g] | ~rst_n;
            irq_edge_capture #(.EDGE(EDGE_G)) cap_i (
                .pin_i (pin_i[g]),
                .clr_i (cap_clr[g]),
                .cap_o (cap[g])
            );
        end
    endgenerate

    irq_sync_2ff #(.W(LINES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (cap),
        .stage1_o (sync_s1),
        .stage2_o (sync_pulse)
    );

    irq_flag_reg #(.W(LINES), .SER_LINE(SER_LINE)) flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pulse_i (sync_pulse),
        .int_stb_i   (int_stb_i),
        .rx_stb_i    (ser_rx_stb_i),
        .ser_mode_i  (ser_mode_i),
        .clr_i       (flag_clr_i),
        .flag_o      (flag_o)
    );

endmodule

// File: rtl/irq_capture_sync_chk.sv
module irq_capture_sync_chk #(
    parameter int LINES    = 4,
    parameter int SER_LINE = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_mode_i,
    input logic [LINES-1:0] int_stb_i,
    input logic             ser_rx_stb_i,
    input logic [LINES-1:0] flag_clr_i,
    input logic [LINES-1:0] flag_o,
    input logic [LINES-1:0] sync_pulse
);

    logic [LINES-1:0] may_set;

    always_comb begin
        may_set = int_stb_i | sync_pulse;
        if (ser_mode_i) may_set[SER_LINE] = int_stb_i[SER_LINE] | ser_rx_stb_i;
    end

    // R10: flags read zero while reset is held
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |-> flag_o == '0);

    // R7: a set flag without its clear bit stays set
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(flag_o & ~flag_clr_i)) == $past(flag_o & ~flag_clr_i)));

    // R4 / R8: an internal strobe always leaves its flag set, clear or not
    assert_int_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(int_stb_i)) == $past(int_stb_i)));

    // R3: a flag only rises when some request source was active
    assert_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(may_set)) == '0));

    // R11: the synchronized request is a single-cycle pulse
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sync_pulse & $past(sync_pulse)) == '0));

    // R5: in serial mode the shared pin cannot raise its flag
    assert_pin_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode_i && !int_stb_i[SER_LINE] && !ser_rx_stb_i && !flag_o[SER_LINE])
        |=> !flag_o[SER_LINE]);

    // R6: outside serial mode the receiver strobe cannot raise the flag
    assert_rx_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode_i && !int_stb_i[SER_LINE] && !sync_pulse[SER_LINE] && !flag_o[SER_LINE])
        |=> !flag_o[SER_LINE]);

endmodule

bind irq_capture_sync irq_capture_sync_chk #(
    .LINES    (LINES),
    .SER_LINE (SER_LINE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_mode_i   (ser_mode_i),
    .int_stb_i    (int_stb_i),
    .ser_rx_stb_i (ser_rx_stb_i),
    .flag_clr_i   (flag_clr_i),
    .flag_o       (flag_o),
    .sync_pulse   (sync_pulse)
);

// File: tb/irq_capture_sync_tb_top.sv
module irq_capture_sync_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    // {ser_mode, pins, int_stb, rx_stb, expected flags}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 4'b0000, 4'b0000, 1'b0, 4'b1001},
        {1'b0, 4'b0110, 4'b0000, 1'b0, 4'b0110},
        {1'b0, 4'b1111, 4'b0000, 1'b0, 4'b0000},
        {1'b1, 4'b0111, 4'b0000, 1'b0, 4'b0000},
        {1'b1, 4'b0111, 4'b0000, 1'b1, 4'b1000},
        {1'b0, 4'b0111, 4'b0000, 1'b1, 4'b0000},
        {1'b0, 4'b0111, 4'b0101, 1'b0, 4'b0101},
        {1'b0, 4'b1111, 4'b0000, 1'b0, 4'b0000},
        {1'b0, 4'b0001, 4'b0010, 1'b0, 4'b1010},
        {1'b1, 4'b1000, 4'b1000, 1'b0, 4'b1001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = 4'b1001;
    logic [3:0] int_stb = '0;
    logic       rx_stb = 1'b0;
    logic       ser_mode = 1'b0;
    logic [3:0] clr = '0;
    logic [3:0] flag;

    int  total = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_capture_sync dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin),
        .int_stb_i    (int_stb),
        .ser_rx_stb_i (rx_stb),
        .ser_mode_i   (ser_mode),
        .flag_clr_i   (clr),
        .flag_o       (flag)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: flags=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_all();
        clr = 4'b1111;
        cyc(1);
        clr = '0;
    endtask

    initial begin
        cyc(1);
        // R10: reset state
        check("R10 reset state", flag, 4'b0000);
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
        check("R10 after release", flag, 4'b0000);

        // Table walk: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            ser_mode = VEC[v][13];
            pin      = VEC[v][12:9];
            int_stb  = VEC[v][8:5];
            rx_stb   = VEC[v][4];
            cyc(1);
            int_stb  = '0;
            rx_stb   = 1'b0;
            cyc(2);
            check($sformatf("R3/R4/R5/R6 vector %0d", v), flag, VEC[v][3:0]);
            clear_all();
        end
        ser_mode = 1'b0;
        cyc(3);

        // R3: rising edge on falling-edge line 0 does nothing
        pin[0] = 1'b1;
        cyc(3);
        check("R3 wrong direction", flag, 4'b0000);

        // R1: narrow low pulse on line 0, shorter than a clock period
        pin[0] = 1'b0;
        #2 pin[0] = 1'b1;
        cyc(3);
        check("R1 narrow pulse captured", flag, 4'b0001);
        clear_all();

        // R2: latency on rising-edge line 1 (currently low)
        pin[1] = 1'b0;
        cyc(2);
        pin[1] = 1'b1;
        cyc(2);
        check("R2 not yet at second edge", flag, 4'b0000);
        cyc(1);
        check("R2 set at third edge", flag, 4'b0010);

        // R11: clear right after the rise; no second set from the same edge
        clr = 4'b0010;
        cyc(1);
        clr = '0;
        cyc(3);
        check("R11 single set per edge", flag, 4'b0000);

        // R9: capture re-armed for a later edge
        pin[1] = 1'b0;
        cyc(2);
        pin[1] = 1'b1;
        cyc(3);
        check("R9 re-armed capture", flag, 4'b0010);

        // R7: hold, and clearing another bit leaves it
        cyc(5);
        check("R7 flag held", flag, 4'b0010);
        clr = 4'b0001;
        cyc(1);
        clr = '0;
        check("R7 other clear ignored", flag, 4'b0010);
        clr = 4'b0010;
        cyc(1);
        clr = '0;
        check("R7 own clear", flag, 4'b0000);

        // R8: set and clear in the same cycle
        int_stb = 4'b0100;
        cyc(1);
        int_stb = 4'b0100;
        clr     = 4'b0100;
        cyc(1);
        int_stb = '0;
        clr     = '0;
        check("R8 set wins over clear", flag, 4'b0100);

        // R10: reset mid-run with strobes and pin edges active
        rst_n   = 1'b0;
        int_stb = 4'b1111;
        cyc(1);
        check("R10 held in reset", flag, 4'b0000);
        pin[1] = 1'b0;
        #2 pin[1] = 1'b1;
        cyc(1);
        int_stb = '0;
        rst_n   = 1'b1;
        cyc(4);
        check("R10 no stale request", flag, 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: flags=%b expected=completion", flag);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule